// File: doc/BRIEF.md
# Interrupt Return Sequencer

This block runs the return-from-interrupt step of a 16-bit processor core. When the decoder issues a one-cycle start pulse, the block reads two words from the downward-growing stack in memory. The first word is the saved status word and the second is the saved program counter. It writes the status word back into the status register first and the program counter last. It then tells the fetch unit to resume. Every saved status bit, including the global interrupt enable (bit 3) and the CPU-off bit (bit 4), is restored exactly as saved. Whatever the service routine wrote into those bits is overwritten.

The block drives a synchronous memory read port: the address and read strobe are presented in one cycle and the data returns in the next. It takes the stack pointer value once, when a start pulse is accepted. It then posts each incremented pointer back through a write strobe. The whole sequence lasts exactly five cycles, through states ST_SR_ADDR, ST_SR_DATA, ST_PC_ADDR, ST_PC_DATA and ST_RESUME, and then returns to ST_IDLE.

The transitions are as follows:
- T_START: ST_IDLE to ST_SR_ADDR, on a start pulse.
- T_SR_WAIT, T_SR_POP, T_PC_WAIT and T_PC_POP: each moves one state along the chain, unconditionally.
- T_FINISH: ST_RESUME back to ST_IDLE.

Top module: `rti_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy_o, done_o, mem_rd_o, sp_we_o, sr_we_o and pc_we_o are all 0.
- R2: A start pulse accepted at a clock edge sets busy_o high for exactly the next five cycles (cycles 1 to 5). done_o is high in cycle 5 only.
- R3: mem_rd_o is high in cycles 1 and 3 only. mem_addr_o is the stack pointer sampled with the start pulse (SP) in cycle 1, and SP+2 in cycle 3.
- R4: sp_we_o is high in cycles 2 and 4 only, with sp_wdata_o equal to SP+2 and then SP+4.
- R5: In cycle 3, sr_we_o is high and sr_wdata_o equals all 16 bits of the word read from SP, unchanged. This includes bit 3 (global enable) and bit 4 (CPU off), whether those bits are 0 or 1.
- R6: In cycle 5, pc_we_o is high and pc_wdata_o equals the word read from SP+2 with bit 0 forced to 0. The status write (cycle 3) always comes before the program counter write.
- R7: A start pulse that arrives in any of cycles 1 to 5 is ignored. The sequence is neither restarted nor lengthened, and busy_o is 0 in cycle 6.
- R8: A start pulse in cycle 6, the first idle cycle, is accepted and begins a full new sequence.
- R9: While busy_o is 0, no memory read and no register write strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle start pulse from the decoder |
| sp_i | input | 16 | Current stack pointer value |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Final cycle; fetch may resume |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 16 | Memory read address |
| sp_we_o | output | 1 | Stack pointer write strobe |
| sp_wdata_o | output | 16 | New stack pointer value |
| sr_we_o | output | 1 | Status register write strobe |
| sr_wdata_o | output | 16 | Restored status word |
| pc_we_o | output | 1 | Program counter write strobe |
| pc_wdata_o | output | 16 | Restored, word-aligned program counter |

## Verification
Cycles are counted from the edge that accepts the start pulse. The read strobes are due in cycles 1 and 3, the pointer writes in cycles 2 and 4, the status write in cycle 3, and the program counter write together with done in cycle 5. Cycle 6 must be idle. The bench drives start on a falling edge and then inspects every port at each following falling edge, naming the cycle number. Each result is therefore checked in the exact cycle it is due, and a strobe that arrives one cycle early or late is reported. A start pulse is also injected in a chosen cycle of the sequence, which tests both the ignore rule and the back-to-back case at the cycle level.

// File: rtl/rti_pkg.sv
package rti_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SR_ADDR = 3'd1,
        ST_SR_DATA = 3'd2,
        ST_PC_ADDR = 3'd3,
        ST_PC_DATA = 3'd4,
        ST_RESUME  = 3'd5
    } rti_state_e;

    typedef struct packed {
        logic busy;
        logic done;
        logic mem_rd;
        logic sp_load;
        logic sp_step;
        logic cap_sr;
        logic cap_pc;
        logic sr_we;
        logic pc_we;
    } rti_ctrl_t;

endpackage

// File: rtl/rti_fsm.sv
module rti_fsm
    import rti_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    output rti_ctrl_t  ctrl_o
);

    rti_state_e state_q;
    rti_state_e state_d;

    // State register and next-state decode
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_SR_ADDR;   // T_START
            ST_SR_ADDR: state_d = ST_SR_DATA;                // T_SR_WAIT
            ST_SR_DATA: state_d = ST_PC_ADDR;                // T_SR_POP
            ST_PC_ADDR: state_d = ST_PC_DATA;                // T_PC_WAIT
            ST_PC_DATA: state_d = ST_RESUME;                 // T_PC_POP
            ST_RESUME:  state_d = ST_IDLE;                   // T_FINISH
            default:    state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        ctrl_o         = '0;
        ctrl_o.sp_load = (state_q == ST_IDLE) && start_i;
        unique case (state_q)
            ST_IDLE: ;
            ST_SR_ADDR: begin
                ctrl_o.busy   = 1'b1;
                ctrl_o.mem_rd = 1'b1;
            end
            ST_SR_DATA: begin
                ctrl_o.busy    = 1'b1;
                ctrl_o.cap_sr  = 1'b1;
                ctrl_o.sp_step = 1'b1;
            end
            ST_PC_ADDR: begin
                ctrl_o.busy   = 1'b1;
                ctrl_o.mem_rd = 1'b1;
                ctrl_o.sr_we  = 1'b1;
            end
            ST_PC_DATA: begin
                ctrl_o.busy    = 1'b1;
                ctrl_o.cap_pc  = 1'b1;
                ctrl_o.sp_step = 1'b1;
            end
            ST_RESUME: begin
                ctrl_o.busy  = 1'b1;
                ctrl_o.done  = 1'b1;
                ctrl_o.pc_we = 1'b1;
            end
            default: ;
        endcase
    end

    // R2: the final state always hands back to idle
    p_resume_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RESUME |=> state_q == ST_IDLE);

    // R7: a start seen mid-sequence never drops the block back to idle early
    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_RESUME && start_i) |=> state_q != ST_IDLE);

endmodule

// File: rtl/rti_pointer.sv
module rti_pointer #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] sp_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] next_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

    logic [ADDR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (load_i) ptr_q <= sp_i;
        else if (step_i) ptr_q <= ptr_q + STEP;
    end

    assign addr_o = ptr_q;
    assign next_o = ptr_q + STEP;

endmodule

// File: rtl/rti_capture.sv
module rti_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_sr_i,
    input  logic              cap_pc_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] sr_o,
    output logic [DATA_W-1:0] pc_o
);

    logic [DATA_W-1:0] sr_q;
    logic [DATA_W-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
            pc_q <= '0;
        end else begin
            if (cap_sr_i) sr_q <= rdata_i;
            if (cap_pc_i) pc_q <= rdata_i;
        end
    end

    assign sr_o = sr_q;
    assign pc_o = {pc_q[DATA_W-1:1], 1'b0};

endmodule

// File: rtl/rti_sequencer.sv
module rti_sequencer
    import rti_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              sp_we_o,
    output logic [ADDR_W-1:0] sp_wdata_o,
    output logic              sr_we_o,
    output logic [DATA_W-1:0] sr_wdata_o,
    output logic              pc_we_o,
    output logic [DATA_W-1:0] pc_wdata_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

    rti_ctrl_t ctrl;

    rti_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .ctrl_o  (ctrl)
    );

    rti_pointer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ctrl.sp_load),
        .step_i (ctrl.sp_step),
        .sp_i   (sp_i),
        .addr_o (mem_addr_o),
        .next_o (sp_wdata_o)
    );

    rti_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_sr_i (ctrl.cap_sr),
        .cap_pc_i (ctrl.cap_pc),
        .rdata_i  (mem_rdata_i),
        .sr_o     (sr_wdata_o),
        .pc_o     (pc_wdata_o)
    );

    assign busy_o   = ctrl.busy;
    assign done_o   = ctrl.done;
    assign mem_rd_o = ctrl.mem_rd;
    assign sp_we_o  = ctrl.sp_step;
    assign sr_we_o  = ctrl.sr_we;
    assign pc_we_o  = ctrl.pc_we;

    // R9: nothing is strobed while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(mem_rd_o || sp_we_o || sr_we_o || pc_we_o));

    // R6: the status write precedes the program counter write by two cycles
    p_sr_before_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we_o |-> $past(sr_we_o, 2));

    // R2: done is followed by an idle cycle
    p_done_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // R4: the second pointer write is one step above the first
    p_sp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_we_o && $past(sp_we_o, 2)) |-> sp_wdata_o == $past(sp_wdata_o, 2) + STEP);

    // R3: the second read address is one step above the first
    p_rd_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && $past(mem_rd_o, 2)) |-> mem_addr_o == $past(mem_addr_o, 2) + STEP);

endmodule

// File: tb/tb_rti_sequencer.sv
module tb_rti_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] sp_i = '0;
    logic [15:0] mem_rdata_i = '0;
    logic        busy_o, done_o, mem_rd_o, sp_we_o, sr_we_o, pc_we_o;
    logic [15:0] mem_addr_o, sp_wdata_o, sr_wdata_o, pc_wdata_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [15:0] mem [16];

    always #5 clk = ~clk;

    // Synchronous read memory: data appears the cycle after the strobe
    always @(posedge clk) if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o[4:1]];

    rti_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sp_i(sp_i),
        .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .sp_we_o(sp_we_o),
        .sp_wdata_o(sp_wdata_o), .sr_we_o(sr_we_o), .sr_wdata_o(sr_wdata_o),
        .pc_we_o(pc_we_o), .pc_wdata_o(pc_wdata_o)
    );

    // {sp, saved status, saved pc, cycle in which to inject a stray start (0 = none)}
    localparam logic [51:0] VEC [6] = '{
        {16'h0010, 16'h0018, 16'h8001, 4'd0},
        {16'h001C, 16'h0000, 16'h4422, 4'd0},
        {16'h0000, 16'hFFFF, 16'hFFFF, 4'd2},
        {16'h0006, 16'h0108, 16'hC000, 4'd4},
        {16'h0014, 16'h0010, 16'h1235, 4'd1},
        {16'h000A, 16'h0008, 16'h0002, 4'd5}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Starts at a falling edge, returns at the falling edge of cycle 6
    task automatic run_seq(input logic [15:0] sp, input logic [15:0] sr,
                           input logic [15:0] pc, input int inject);
        mem[sp[4:1]]        = sr;
        mem[sp[4:1] + 4'd1] = pc;
        sp_i    = sp;
        start_i = 1'b1;
        for (int c = 1; c <= 6; c++) begin
            @(negedge clk);
            start_i = 1'b0;
            sp_i    = 16'hBEEE;
            if (c <= 5) chk("R2 busy", {31'd0, busy_o}, 32'd1);
            chk("R2 done", {31'd0, done_o}, {31'd0, c == 5});
            chk("R3 read strobe", {31'd0, mem_rd_o}, {31'd0, c == 1 || c == 3});
            chk("R4 sp strobe", {31'd0, sp_we_o}, {31'd0, c == 2 || c == 4});
            chk("R5 sr strobe", {31'd0, sr_we_o}, {31'd0, c == 3});
            chk("R6 pc strobe", {31'd0, pc_we_o}, {31'd0, c == 5});
            if (c == 1) chk("R3 first addr", {16'd0, mem_addr_o}, {16'd0, sp});
            if (c == 3) chk("R3 second addr", {16'd0, mem_addr_o}, {16'd0, sp + 16'd2});
            if (c == 2) chk("R4 sp+2", {16'd0, sp_wdata_o}, {16'd0, sp + 16'd2});
            if (c == 4) chk("R4 sp+4", {16'd0, sp_wdata_o}, {16'd0, sp + 16'd4});
            if (c == 3) chk("R5 status word", {16'd0, sr_wdata_o}, {16'd0, sr});
            if (c == 5) chk("R6 pc word", {16'd0, pc_wdata_o}, {16'd0, pc & 16'hFFFE});
            if (c == 6) chk(inject != 0 ? "R7 stray start ignored" : "R2 idle after five",
                            {31'd0, busy_o}, 32'd0);
            if (c == inject) start_i = 1'b1;
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        chk("R1 reset busy", {31'd0, busy_o}, 32'd0);
        chk("R1 reset strobes", {28'd0, mem_rd_o, sp_we_o, sr_we_o, pc_we_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {30'd0, busy_o, done_o}, 32'd0);
        // R9: idle with no start for several cycles
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R9 idle quiet", {27'd0, busy_o, mem_rd_o, sp_we_o, sr_we_o, pc_we_o}, 32'd0);
        end
        // Vector table walk
        for (int v = 0; v < 6; v++) begin
            run_seq(VEC[v][51:36], VEC[v][35:20], VEC[v][19:4], int'(VEC[v][3:0]));
            @(negedge clk);
        end
        // R8: back-to-back, second start in the first idle cycle
        run_seq(16'h0002, 16'h0018, 16'hA5A5, 0);
        run_seq(16'h0018, 16'h0000, 16'h0F0E, 0);
        chk("R8 back-to-back idle", {31'd0, busy_o}, 32'd0);
        // R5: service routine values replaced by saved bits (GIE/CPU-off cleared)
        run_seq(16'h000C, 16'h0000, 16'h3000, 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule